// File: doc/BRIEF.md
# Load-Use Stall Detector

This block belongs to the decode stage of a five-stage in-order pipeline. It looks at the instruction that is now in the execute stage. If that instruction is a load, the block compares the load's destination register, carried in the instruction's rt field, against both source register fields of the instruction being decoded. When either field names the load's target, the loaded value is not ready yet. It can only be forwarded from the memory/writeback stage one cycle later, so the pipeline has to wait one cycle.

On such a match the block asks for a one-cycle stall. It freezes the front end by dropping the program counter write enable and the fetch/decode register write enable, so the same instruction is decoded again on the next cycle. It also clears every control bit that enters the decode/execute register, which turns that slot into a bubble with no architectural effect. One cycle later the load has moved on to the memory stage and the request clears by itself. The logic is purely combinational and sits between the pipeline registers that surround it.

Top module: `load_use_stall_unit`

## Requirements
- R1: With the execute-stage load flag high, `stall` is 1 whenever `ex_rt` equals `id_rs` and the register is not excluded by R4.
- R2: With the execute-stage load flag high, `stall` is 1 whenever `ex_rt` equals `id_rt` and the register is not excluded by R4.
- R3: With the execute-stage load flag low, `stall` is 0 whatever the register fields hold, including an exact match on `id_rt` or `id_rs`.
- R4: With `SKIP_ZERO` = 1 (default), a load whose `ex_rt` is register 0 never stalls, even when a source field is also 0.
- R5: A load whose `ex_rt` equals neither `id_rs` nor `id_rt` gives `stall` = 0.
- R6: `pc_we` and `ifid_we` are both the inverse of `stall`: 1 when the front end may advance, 0 while it is held.
- R7: While `stall` is 1, `ex_ctrl_out` is all zeros. Otherwise it equals `id_ctrl_in` bit for bit.
- R8: In a pipeline that feeds `ex_ctrl_out` back into decode/execute, a load followed at once by a dependent instruction gives exactly one stall cycle. The program counter and the decoded instruction are unchanged on the cycle after the stall, and the stall is then gone.
- R9: When both source fields name the load's target, the result is the same single stall as a match on one field.
- R10: With `SKIP_ZERO` = 0, register 0 is treated like any other register, so a load to register 0 followed by a read of register 0 stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_mem_read | input | 1 | Execute-stage instruction is a load (reads data memory) |
| ex_rt | input | AW | Destination register of the execute-stage load |
| id_rs | input | AW | First source register field of the instruction being decoded |
| id_rt | input | AW | Second source register field of the instruction being decoded |
| id_ctrl_in | input | CW | Control bits produced by decode for the decode/execute register |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ex_ctrl_out | output | CW | Control bits to write into decode/execute (zero for a bubble) |
| stall | output | 1 | Load-use hazard detected this cycle |

## Verification
The bench builds two copies of the block, both with AW = 5 and CW = 8. The first uses `SKIP_ZERO` = 1 and the second `SKIP_ZERO` = 0. Running them side by side shows that register 0 is exempt in one copy and treated as an ordinary register in the other, so the same stimulus yields opposite stall decisions. The 8-bit control word lets the bench check that a bubble clears every bit of a busy control pattern. The bench also wraps the first copy in a small fetch/decode/execute model whose decode/execute slot is written from `ex_ctrl_out`, so the bubble travels back into the load flag and the one-cycle length of the stall can be seen.

// File: rtl/luh_pkg.sv
package luh_pkg;

  // Widest register index any instance may use.
  localparam int MAX_AW = 8;

  typedef logic [MAX_AW-1:0] reg_idx_t;

  // True when a source field names the same register as the load target.
  // Register 0 is excluded when skip_zero is set.
  function automatic logic names_target(reg_idx_t dst, reg_idx_t src, logic skip_zero);
    logic same;
    logic zero_dst;
    same     = (dst == src);
    zero_dst = (dst == '0);
    return same && !(skip_zero && zero_dst);
  endfunction

endpackage

// File: rtl/luh_src_match.sv
module luh_src_match #(
  parameter int AW        = 5,
  parameter bit SKIP_ZERO = 1'b1
) (
  input  logic          load_valid,
  input  logic [AW-1:0] load_dst,
  input  logic [AW-1:0] src_reg,
  output logic          hit
);
  import luh_pkg::*;

  reg_idx_t dst_wide;
  reg_idx_t src_wide;

  assign dst_wide = reg_idx_t'(load_dst);
  assign src_wide = reg_idx_t'(src_reg);
  assign hit      = load_valid && names_target(dst_wide, src_wide, SKIP_ZERO);

endmodule

// File: rtl/luh_bubble_mux.sv
module luh_bubble_mux #(
  parameter int CW = 8
) (
  input  logic          kill,
  input  logic [CW-1:0] ctrl_in,
  output logic [CW-1:0] ctrl_out
);

  genvar b;
  generate
    for (b = 0; b < CW; b++) begin : g_bit
      assign ctrl_out[b] = ctrl_in[b] & ~kill;
    end
  endgenerate

endmodule

// File: rtl/load_use_stall_unit.sv
module load_use_stall_unit #(
  parameter int AW        = 5,
  parameter int CW        = 8,
  parameter bit SKIP_ZERO = 1'b1
) (
  input  logic          ex_mem_read,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic [CW-1:0] id_ctrl_in,
  output logic          pc_we,
  output logic          ifid_we,
  output logic [CW-1:0] ex_ctrl_out,
  output logic          stall
);

  localparam int NSRC = 2;

  logic [AW-1:0] src_fields [NSRC];
  logic [NSRC-1:0] src_hits;

  // Named events for the checker.
  logic hit_rs;
  logic hit_rt;

  assign src_fields[0] = id_rs;
  assign src_fields[1] = id_rt;

  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      luh_src_match #(
        .AW        (AW),
        .SKIP_ZERO (SKIP_ZERO)
      ) u_match (
        .load_valid (ex_mem_read),
        .load_dst   (ex_rt),
        .src_reg    (src_fields[s]),
        .hit        (src_hits[s])
      );
    end
  endgenerate

  assign hit_rs = src_hits[0];
  assign hit_rt = src_hits[1];

  assign stall   = |src_hits;
  assign pc_we   = ~stall;
  assign ifid_we = ~stall;

  luh_bubble_mux #(
    .CW (CW)
  ) u_bubble (
    .kill     (stall),
    .ctrl_in  (id_ctrl_in),
    .ctrl_out (ex_ctrl_out)
  );

endmodule

// File: rtl/luh_checker.sv
module luh_checker #(
  parameter int AW        = 5,
  parameter int CW        = 8,
  parameter bit SKIP_ZERO = 1'b1
) (
  input logic          ex_mem_read,
  input logic [AW-1:0] ex_rt,
  input logic [AW-1:0] id_rs,
  input logic [AW-1:0] id_rt,
  input logic [CW-1:0] id_ctrl_in,
  input logic          pc_we,
  input logic          ifid_we,
  input logic [CW-1:0] ex_ctrl_out,
  input logic          stall,
  input logic          hit_rs,
  input logic          hit_rt
);

  logic dst_ok;
  logic known;

  assign dst_ok = !(SKIP_ZERO && (ex_rt == '0));
  assign known  = !$isunknown({ex_mem_read, ex_rt, id_rs, id_rt, id_ctrl_in,
                               pc_we, ifid_we, ex_ctrl_out, stall, hit_rs, hit_rt});

  always_comb begin
    if (known) begin
      assert_rs_match_R1: assert (!(ex_mem_read && dst_ok && ex_rt == id_rs) || stall)
        else $error("rs match without stall");
      assert_rt_match_R2: assert (!(ex_mem_read && dst_ok && ex_rt == id_rt) || stall)
        else $error("rt match without stall");
      assert_no_load_R3: assert (ex_mem_read || !stall)
        else $error("stall without load");
      assert_zero_dst_R4: assert (!(SKIP_ZERO && ex_rt == '0) || !stall)
        else $error("stall on register 0");
      assert_unrelated_R5: assert (!stall || ex_rt == id_rs || ex_rt == id_rt)
        else $error("stall on unrelated registers");
      assert_front_hold_R6: assert ((pc_we != stall) && (ifid_we != stall))
        else $error("front-end enables disagree with stall");
      assert_bubble_R7: assert (stall ? (ex_ctrl_out == '0) : (ex_ctrl_out == id_ctrl_in))
        else $error("control bits wrong");
      assert_both_R9: assert (!(hit_rs && hit_rt) || (stall && !pc_we))
        else $error("double match not a single stall");
    end
  end

endmodule

bind load_use_stall_unit luh_checker #(
  .AW        (AW),
  .CW        (CW),
  .SKIP_ZERO (SKIP_ZERO)
) u_chk (
  .ex_mem_read (ex_mem_read),
  .ex_rt       (ex_rt),
  .id_rs       (id_rs),
  .id_rt       (id_rt),
  .id_ctrl_in  (id_ctrl_in),
  .pc_we       (pc_we),
  .ifid_we     (ifid_we),
  .ex_ctrl_out (ex_ctrl_out),
  .stall       (stall),
  .hit_rs      (hit_rs),
  .hit_rt      (hit_rt)
);

// File: tb/load_use_stall_unit_tb.sv
module load_use_stall_unit_tb;

  localparam int AW = 5;
  localparam int CW = 8;

  // Bench instruction: control bit 0 marks a load.
  typedef struct packed {
    logic [AW-1:0] rs;
    logic [AW-1:0] rt;
    logic [CW-1:0] ctrl;
  } ins_t;

  localparam logic [CW-1:0] C_LOAD = 8'h03;
  localparam logic [CW-1:0] C_ALU  = 8'hA6;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  // Pipeline-model state (also used as direct stimulus).
  logic [CW-1:0] idex_ctrl = '0;
  logic [AW-1:0] idex_rt   = '0;
  ins_t          ifid      = '0;
  int            pc        = 0;
  ins_t          prog [8];

  logic          pc_we, ifid_we, stall;
  logic [CW-1:0] ex_ctrl_out;
  logic          z_pc_we, z_ifid_we, z_stall;
  logic [CW-1:0] z_ex_ctrl_out;

  load_use_stall_unit #(.AW(AW), .CW(CW), .SKIP_ZERO(1'b1)) u_dut (
    .ex_mem_read (idex_ctrl[0]),
    .ex_rt       (idex_rt),
    .id_rs       (ifid.rs),
    .id_rt       (ifid.rt),
    .id_ctrl_in  (ifid.ctrl),
    .pc_we       (pc_we),
    .ifid_we     (ifid_we),
    .ex_ctrl_out (ex_ctrl_out),
    .stall       (stall)
  );

  load_use_stall_unit #(.AW(AW), .CW(CW), .SKIP_ZERO(1'b0)) u_dut_z (
    .ex_mem_read (idex_ctrl[0]),
    .ex_rt       (idex_rt),
    .id_rs       (ifid.rs),
    .id_rt       (ifid.rt),
    .id_ctrl_in  (ifid.ctrl),
    .pc_we       (z_pc_we),
    .ifid_we     (z_ifid_we),
    .ex_ctrl_out (z_ex_ctrl_out),
    .stall       (z_stall)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Apply one combinational pattern and check every output of u_dut.
  task automatic apply(input logic ld, input logic [AW-1:0] ert,
                       input logic [AW-1:0] rs, input logic [AW-1:0] rt,
                       input logic [CW-1:0] ctrl, input bit exp_stall,
                       input string req);
    logic [CW-1:0] exp_ctrl;
    @(negedge clk);
    idex_ctrl = ld ? C_LOAD : C_ALU & 8'hFE;
    idex_rt   = ert;
    ifid      = '{rs: rs, rt: rt, ctrl: ctrl};
    #1;
    exp_ctrl = exp_stall ? '0 : ctrl;
    chk(stall == exp_stall, req, "stall", stall, exp_stall);
    chk(pc_we == !exp_stall && ifid_we == !exp_stall, "R6", "front-end enables",
        {pc_we, ifid_we}, {!exp_stall, !exp_stall});
    chk(ex_ctrl_out == exp_ctrl, "R7", "ex_ctrl_out", ex_ctrl_out, exp_ctrl);
  endtask

  task automatic test_reset_idle();
    apply(1'b0, '0, '0, '0, '0, 1'b0, "R3");
    chk(z_stall == 1'b0, "R3", "idle stall (no zero skip)", z_stall, 0);
  endtask

  task automatic test_direct_matches();
    apply(1'b1, 5'd5, 5'd5, 5'd9, C_ALU, 1'b1, "R1");
    apply(1'b1, 5'd7, 5'd2, 5'd7, C_ALU, 1'b1, "R2");
    apply(1'b1, 5'd31, 5'd31, 5'd31, 8'hFF, 1'b1, "R9");
    apply(1'b1, 5'd4, 5'd3, 5'd6, C_ALU, 1'b0, "R5");
    apply(1'b0, 5'd5, 5'd5, 5'd5, C_ALU, 1'b0, "R3");
  endtask

  task automatic test_zero_register();
    apply(1'b1, 5'd0, 5'd0, 5'd0, C_ALU, 1'b0, "R4");
    chk(z_stall == 1'b1, "R10", "stall on reg 0 with SKIP_ZERO=0", z_stall, 1);
    chk(z_ex_ctrl_out == '0, "R10", "bubble on reg 0 with SKIP_ZERO=0", z_ex_ctrl_out, 0);
    chk(z_pc_we == 1'b0 && z_ifid_we == 1'b0, "R10", "front hold with SKIP_ZERO=0",
        {z_pc_we, z_ifid_we}, 0);
  endtask

  // Advance the bench pipeline model by one clock.
  task automatic step();
    logic [CW-1:0] s_ctrl;
    logic          s_pcwe, s_ifwe;
    s_ctrl = ex_ctrl_out;
    s_pcwe = pc_we;
    s_ifwe = ifid_we;
    @(posedge clk);
    idex_ctrl = s_ctrl;
    idex_rt   = ifid.rt;
    if (s_ifwe) ifid = prog[pc % 8];
    if (s_pcwe) pc++;
    @(negedge clk);
  endtask

  task automatic run_prog(input ins_t i0, input ins_t i1, input ins_t i2,
                          input int exp_stalls, input string req);
    int nst;
    int held_pc;
    ins_t held_ins;
    bit after;
    @(negedge clk);
    for (int k = 0; k < 8; k++) prog[k] = '0;
    prog[0] = i0; prog[1] = i1; prog[2] = i2;
    idex_ctrl = '0; idex_rt = '0; ifid = '0; pc = 0;
    #1;
    nst = 0; after = 1'b0; held_pc = 0; held_ins = '0;
    for (int c = 0; c < 7; c++) begin
      if (after) begin
        chk(pc == held_pc, "R8", "pc held after stall", pc, held_pc);
        chk(ifid == held_ins, "R8", "instruction decoded again", ifid, held_ins);
        chk(stall == 1'b0, "R8", "stall cleared after one cycle", stall, 0);
        after = 1'b0;
      end
      if (stall) begin
        nst++;
        chk(ex_ctrl_out == '0, "R7", "bubble in pipeline", ex_ctrl_out, 0);
        held_pc  = pc;
        held_ins = ifid;
        after    = 1'b1;
      end
      step();
    end
    chk(nst == exp_stalls, req, "stall cycles in sequence", nst, exp_stalls);
  endtask

  task automatic test_load_then_dependent();
    run_prog('{rs: 5'd1, rt: 5'd5, ctrl: C_LOAD},
             '{rs: 5'd5, rt: 5'd6, ctrl: C_ALU},
             '{rs: 5'd7, rt: 5'd8, ctrl: C_ALU}, 1, "R8");
  endtask

  task automatic test_load_then_independent();
    run_prog('{rs: 5'd1, rt: 5'd5, ctrl: C_LOAD},
             '{rs: 5'd2, rt: 5'd3, ctrl: C_ALU},
             '{rs: 5'd5, rt: 5'd5, ctrl: C_ALU}, 0, "R5");
  endtask

  task automatic test_nonload_matching_rt();
    run_prog('{rs: 5'd1, rt: 5'd5, ctrl: C_ALU & 8'hFE},
             '{rs: 5'd5, rt: 5'd5, ctrl: C_ALU},
             '{rs: 5'd7, rt: 5'd8, ctrl: C_ALU}, 0, "R3");
  endtask

  initial begin
    test_reset_idle();
    test_direct_matches();
    test_zero_register();
    test_load_then_dependent();
    test_load_then_independent();
    test_nonload_matching_rt();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule